// File: doc/BRIEF.md
# Hypercube Lane Exchange Network

This block moves data between the lanes of a wide SIMD array. It has one pipeline stage per bit of the lane index, so an array of 2^LANE_BITS lanes has LANE_BITS stages. In every stage each lane keeps its own value from the stage before, or takes the value of a partner lane whose index differs from its own in exactly one bit. There are two kinds of partner. The near partner follows an ascending bit order: stage k flips bit k. The far partner follows a descending bit order: stage k flips bit LANE_BITS-1-k. One pipeline can therefore run replication and broadcast patterns, which work upward through the index bits, and sort and merge exchange patterns, which work downward.

The switches are set from data. A controller computes two select bits per lane and per stage from key values, places them on a wide configuration bus and pulses a load strobe once. The settings are then used for a stream of payload beats of any length, one beat per clock. Each beat comes out a fixed LANE_BITS cycles later. The lane word width is a parameter, so the switch can carry half-words or narrower slices to save area. A valid flag travels with each beat.

Top module: `hcube_router`

## Requirements
- R1: A beat presented with in_valid high appears on out_data with out_valid high exactly LANE_BITS clock cycles later (4 with the defaults), and out_valid is low in every cycle that has no such beat.
- R2: Select code 2'b00 in stage k makes each lane keep its own value from stage k-1.
- R3: Select code 2'b01 in stage k makes lane l take the stage k-1 value of lane l XOR 2^k (the near edge).
- R4: Select code 2'b10 in stage k makes lane l take the stage k-1 value of lane l XOR 2^(LANE_BITS-1-k) (the far edge).
- R5: Select code 2'b11 in stage k drives zero for that lane in that stage.
- R6: The select code for stage k and lane l lies at cfg_sel[2*(k*2^LANE_BITS+l) +: 2]. The whole bus is captured at a clock edge where cfg_load is high, and beats that enter at any later edge use the new codes.
- R7: Captured settings persist across any number of beats, and changes on cfg_sel while cfg_load is low have no effect on the routing.
- R8: Beats may enter on consecutive cycles, and each one is routed independently with the current settings.
- R9: While out_valid is low, out_data holds its last value.
- R10: Lane l uses bits [l*DATA_W +: DATA_W] of in_data and of out_data.
- R11: rst_n low asynchronously clears out_valid, out_data and all settings (settings clear to code 2'b00). After rst_n rises, the block leaves reset at the second rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Strobe that captures the full switch configuration |
| cfg_sel | input | 2*LANE_BITS*2^LANE_BITS | Two select bits per stage and lane |
| in_valid | input | 1 | Payload beat present on in_data |
| in_data | input | DATA_W*2^LANE_BITS | Payload, one word per lane |
| out_valid | output | 1 | Routed beat present on out_data |
| out_data | output | DATA_W*2^LANE_BITS | Routed payload, one word per lane |

## Verification
The bench enables one edge kind in one stage at a time and checks that every lane receives the value of the lane that differs in exactly the expected bit. A design that mixed up the near and far orderings, or flipped the wrong bit, would deliver the wrong lane. A one-to-all broadcast and a zero code on a single lane check the bit-field placement on the configuration bus, since an offset mistake moves the effect to another lane or stage. Back-to-back streams with random settings are compared against a software model cycle by cycle to expose latency errors and valid misalignment. A final run after cfg_sel changes without a load strobe shows whether the settings leak through or get lost.

// File: rtl/hcube_pkg.sv
package hcube_pkg;

  // Per-lane, per-stage switch select code
  typedef enum logic [1:0] {
    SW_KEEP = 2'b00,   // own lane, previous stage
    SW_NEAR = 2'b01,   // partner across bit k
    SW_FAR  = 2'b10,   // partner across bit (LANE_BITS-1-k)
    SW_NULL = 2'b11    // zero word
  } sw_sel_e;

  localparam int unsigned SEL_W = 2;

endpackage

// File: rtl/hcube_cfg_store.sv
module hcube_cfg_store #(
  parameter int unsigned LANE_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [CFG_W-1:0]     sel_in,
  output logic [CFG_W-1:0]     sel_q
);

  localparam int unsigned LANES = 1 << LANE_BITS;
  localparam int unsigned CFG_W = hcube_pkg::SEL_W * LANE_BITS * LANES;

  logic [CFG_W-1:0] sel_d;
  logic [CFG_W-1:0] sel_r;

  // next state: capture only on the load strobe
  always_comb begin
    sel_d = sel_r;
    if (load) begin
      sel_d = sel_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_r <= '0;
    end else begin
      sel_r <= sel_d;
    end
  end

  assign sel_q = sel_r;

endmodule

// File: rtl/hcube_stage.sv
module hcube_stage
  import hcube_pkg::*;
#(
  parameter int unsigned LANE_BITS = 4,
  parameter int unsigned DATA_W    = 9,
  parameter int unsigned STAGE     = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [BUS_W-1:0]      in_data,
  input  logic [SELS_W-1:0]     sel,
  output logic                  out_valid,
  output logic [BUS_W-1:0]      out_data
);

  localparam int unsigned LANES    = 1 << LANE_BITS;
  localparam int unsigned BUS_W    = LANES * DATA_W;
  localparam int unsigned SELS_W   = SEL_W * LANES;
  localparam int unsigned NEAR_BIT = STAGE;
  localparam int unsigned FAR_BIT  = LANE_BITS - 1 - STAGE;

  logic [BUS_W-1:0] data_d;
  logic [BUS_W-1:0] data_q;
  logic             valid_d;
  logic             valid_q;

  // one 3:1 (+zero) selector per lane, partners wired at elaboration
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int unsigned NEAR_L = l ^ (1 << NEAR_BIT);
    localparam int unsigned FAR_L  = l ^ (1 << FAR_BIT);

    logic [DATA_W-1:0] pick;
    sw_sel_e           code;

    assign code = sw_sel_e'(sel[SEL_W*l +: SEL_W]);

    always_comb begin
      case (code)
        SW_KEEP: pick = in_data[l*DATA_W      +: DATA_W];
        SW_NEAR: pick = in_data[NEAR_L*DATA_W +: DATA_W];
        SW_FAR:  pick = in_data[FAR_L*DATA_W  +: DATA_W];
        default: pick = '0;
      endcase
    end

    // clock enable: only a valid beat advances the data register
    assign data_d[l*DATA_W +: DATA_W] = in_valid ? pick : data_q[l*DATA_W +: DATA_W];
  end

  assign valid_d = in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      data_q  <= data_d;
      valid_q <= valid_d;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

endmodule

// File: rtl/hcube_router.sv
module hcube_router
  import hcube_pkg::*;
#(
  parameter int unsigned LANE_BITS = 4,
  parameter int unsigned DATA_W    = 9
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          cfg_load,
  input  logic [SEL_W*LANE_BITS*(1<<LANE_BITS)-1:0]     cfg_sel,
  input  logic                                          in_valid,
  input  logic [DATA_W*(1<<LANE_BITS)-1:0]              in_data,
  output logic                                          out_valid,
  output logic [DATA_W*(1<<LANE_BITS)-1:0]              out_data
);

  localparam int unsigned LANES  = 1 << LANE_BITS;
  localparam int unsigned STAGES = LANE_BITS;
  localparam int unsigned BUS_W  = LANES * DATA_W;
  localparam int unsigned SELS_W = SEL_W * LANES;
  localparam int unsigned CFG_W  = SELS_W * STAGES;

  // reset: asserted asynchronously, released on the second clock edge
  logic [1:0] rst_sync_q;
  logic [1:0] rst_sync_d;
  logic       core_rst_n;

  assign rst_sync_d = {rst_sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= rst_sync_d;
    end
  end

  assign core_rst_n = rst_sync_q[1];

  // switch settings
  logic [CFG_W-1:0] cfg_q;

  hcube_cfg_store #(
    .LANE_BITS (LANE_BITS)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .load   (cfg_load),
    .sel_in (cfg_sel),
    .sel_q  (cfg_q)
  );

  // stage chain
  logic             vchain [STAGES+1];
  logic [BUS_W-1:0] dchain [STAGES+1];

  assign vchain[0] = in_valid;
  assign dchain[0] = in_data;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    hcube_stage #(
      .LANE_BITS (LANE_BITS),
      .DATA_W    (DATA_W),
      .STAGE     (s)
    ) u_stage (
      .clk       (clk),
      .rst_n     (core_rst_n),
      .in_valid  (vchain[s]),
      .in_data   (dchain[s]),
      .sel       (cfg_q[s*SELS_W +: SELS_W]),
      .out_valid (vchain[s+1]),
      .out_data  (dchain[s+1])
    );
  end

  assign out_valid = vchain[STAGES];
  assign out_data  = dchain[STAGES];

endmodule

// File: rtl/hcube_router_chk.sv
module hcube_router_chk #(
  parameter int unsigned LANE_BITS = 4,
  parameter int unsigned DATA_W    = 9
) (
  input logic                                       clk,
  input logic                                       core_rst_n,
  input logic                                       cfg_load,
  input logic [2*LANE_BITS*(1<<LANE_BITS)-1:0]      cfg_sel,
  input logic [2*LANE_BITS*(1<<LANE_BITS)-1:0]      cfg_q,
  input logic                                       in_valid,
  input logic                                       out_valid,
  input logic [DATA_W*(1<<LANE_BITS)-1:0]           out_data
);

  localparam int unsigned STAGES = LANE_BITS;

  // independent record of when beats entered
  logic [STAGES-1:0] entered_q;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      entered_q <= '0;
    end else begin
      entered_q <= {entered_q[STAGES-2:0], in_valid};
    end
  end

  // R1
  latency_match_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    out_valid == entered_q[STAGES-1]);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    !out_valid |-> $stable(out_data));

  // R6
  cfg_capture_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    cfg_load |=> cfg_q == $past(cfg_sel));

  // R7
  cfg_persist_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    !cfg_load |=> $stable(cfg_q));

endmodule

bind hcube_router hcube_router_chk #(
  .LANE_BITS (LANE_BITS),
  .DATA_W    (DATA_W)
) u_chk (
  .clk        (clk),
  .core_rst_n (core_rst_n),
  .cfg_load   (cfg_load),
  .cfg_sel    (cfg_sel),
  .cfg_q      (cfg_q),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .out_data   (out_data)
);

// File: tb/test_hcube_router.sv
module test_hcube_router;

  localparam int LB    = 4;
  localparam int LANES = 1 << LB;
  localparam int W     = 9;
  localparam int CW    = 2 * LB * LANES;
  localparam int DW    = LANES * W;

  logic          clk;
  logic          rst_n;
  logic          cfg_load;
  logic [CW-1:0] cfg_sel;
  logic          in_valid;
  logic [DW-1:0] in_data;
  logic          out_valid;
  logic [DW-1:0] out_data;

  int tests;
  int fails;
  logic [CW-1:0] cur_cfg;

  hcube_router #(.LANE_BITS(LB), .DATA_W(W)) i_hcube_router (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_sel(cfg_sel),
    .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // reference model built from R2..R5, R6, R10
  function automatic logic [DW-1:0] route(input logic [CW-1:0] c, input logic [DW-1:0] d);
    logic [DW-1:0] v;
    logic [DW-1:0] n;
    v = d;
    for (int k = 0; k < LB; k++) begin
      for (int l = 0; l < LANES; l++) begin
        logic [1:0] code;
        int src;
        code = c[2*(k*LANES+l) +: 2];
        case (code)
          2'b00:   src = l;
          2'b01:   src = l ^ (1 << k);
          2'b10:   src = l ^ (1 << (LB-1-k));
          default: src = -1;
        endcase
        n[l*W +: W] = (src < 0) ? '0 : v[src*W +: W];
      end
      v = n;
    end
    return v;
  endfunction

  function automatic logic [DW-1:0] rand_data();
    logic [DW-1:0] d;
    for (int l = 0; l < LANES; l++) d[l*W +: W] = W'($urandom);
    return d;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] set_code(input logic [CW-1:0] c, input int k, input int l, input logic [1:0] code);
    logic [CW-1:0] r;
    r = c;
    r[2*(k*LANES+l) +: 2] = code;
    return r;
  endfunction

  task automatic load_cfg(input logic [CW-1:0] c);
    @(negedge clk);
    cfg_sel  = c;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    cur_cfg  = c;
  endtask

  // single beat; output sampled LB cycles after entry
  task automatic one_beat(input logic [DW-1:0] d, output logic [DW-1:0] o);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (LB-1) @(negedge clk);
    o = out_data;
  endtask

  // back-to-back stream, checked every cycle against the model
  task automatic stream(input string req, input int n);
    logic [DW-1:0] exp_q [16];
    for (int i = 0; i < n + LB + 1; i++) begin
      @(negedge clk);
      if (i >= LB && i - LB < n) begin
        check({req, " R1 valid"}, DW'(out_valid), DW'(1));
        check({req, " R8 data"}, out_data, exp_q[i-LB]);
      end else begin
        check({req, " R1 idle"}, DW'(out_valid), DW'(0));
      end
      if (i < n) begin
        in_valid = 1'b1;
        in_data  = rand_data();
        exp_q[i] = route(cur_cfg, in_data);
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cfg_load = 1'b0; cfg_sel = '0; in_valid = 1'b0; in_data = '0;
    cur_cfg = '0;
    repeat (3) @(negedge clk);
    check("R11 reset valid", DW'(out_valid), DW'(0));
    check("R11 reset data", out_data, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_identity();
    logic [DW-1:0] d, o;
    d = rand_data();
    one_beat(d, o);   // settings cleared to KEEP by reset
    check("R2 keep after reset", o, d);
  endtask

  task automatic t_near();
    for (int s = 0; s < LB; s++) begin
      logic [CW-1:0] c;
      logic [DW-1:0] d, o, e;
      c = '0;
      for (int l = 0; l < LANES; l++) c = set_code(c, s, l, 2'b01);
      load_cfg(c);
      d = rand_data();
      for (int l = 0; l < LANES; l++) e[l*W +: W] = d[(l ^ (1 << s))*W +: W];
      one_beat(d, o);
      check("R3 near edge flips bit k", o, e);
    end
  endtask

  task automatic t_far();
    for (int s = 0; s < LB; s++) begin
      logic [CW-1:0] c;
      logic [DW-1:0] d, o, e;
      c = '0;
      for (int l = 0; l < LANES; l++) c = set_code(c, s, l, 2'b10);
      load_cfg(c);
      d = rand_data();
      for (int l = 0; l < LANES; l++) e[l*W +: W] = d[(l ^ (1 << (LB-1-s)))*W +: W];
      one_beat(d, o);
      check("R4 far edge flips mirrored bit", o, e);
    end
  endtask

  task automatic t_zero();
    logic [CW-1:0] c;
    logic [DW-1:0] d, o, e;
    c = set_code('0, 3, 5, 2'b11);
    load_cfg(c);
    d = rand_data();
    e = d;
    e[5*W +: W] = '0;
    one_beat(d, o);
    check("R5 zero code single lane R10", o, e);
    c = '0;
    for (int l = 0; l < LANES; l++) c = set_code(c, 2, l, 2'b11);
    load_cfg(c);
    one_beat(rand_data(), o);
    check("R5 zero code whole stage", o, '0);
  endtask

  task automatic t_broadcast();
    logic [CW-1:0] c;
    logic [DW-1:0] d, o, e;
    c = '0;
    for (int k = 0; k < LB; k++)
      for (int l = 0; l < LANES; l++)
        if (((l >> k) & 1) == 1) c = set_code(c, k, l, 2'b01);
    load_cfg(c);
    d = rand_data();
    for (int l = 0; l < LANES; l++) e[l*W +: W] = d[W-1:0];
    one_beat(d, o);
    check("R6 broadcast lane 0 layout", o, e);
    @(negedge clk); @(negedge clk);
    check("R9 hold while idle", out_data, e);
  endtask

  task automatic t_random_stream();
    logic [CW-1:0] c;
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < CW; i += 32) c[i +: 32] = $urandom;
      load_cfg(c);
      stream("R8 random cfg", 7);
    end
  endtask

  task automatic t_persist();
    // R7: bus changes without the strobe, old routing must remain
    @(negedge clk);
    cfg_sel = ~cur_cfg;
    stream("R7 persist ignore cfg_sel", 5);
  endtask

  initial begin
    tests = 0;
    fails = 0;
    t_reset();
    t_identity();
    t_near();
    t_far();
    t_zero();
    t_broadcast();
    t_random_stream();
    t_persist();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule